// File: doc/BRIEF.md
# Chopper Current-Regulation PWM Controller

This block decides when the low-side (sink) switches of one bridge phase conduct, so that the winding current stays near a nominal value. A comparison of actual against nominal current is made outside the block. It arrives as a one-bit flag that is already synchronised, and it is high while the actual current is above nominal. A set/reset state bit drives the sink-enable output. Each new switching cycle sets the bit, and a comparator trip clears it.

In timer mode, two counters take the place of an external RC network. The first counts a charge interval of programmable length, which works as a minimum on-time. The second counts a discharge (off) interval. The discharge interval never begins before the charge interval has run its full length, even when the current trips early. This keeps the cycle length constant at very small currents. In sync mode, the counters stay idle. A falling edge on an external sync input starts each on-phase, but only while the current is below nominal. Whenever the bridge is disabled, the sink output is held off and the timers are held at their start.

Top module: `chop_current_ctrl`

## Requirements
- R1: During reset and while `bridgeEn` is low, `sinkOn`, `tripPulse` and `inDischarge` are 0. Dropping `bridgeEn` clears `sinkOn` and `inDischarge` at the next rising edge. Enabling again restarts the timers from the beginning of a charge interval.
- R2: In timer mode (`syncMode`=0), the first rising edge with `bridgeEn` high sets `sinkOn`. The charge interval covers `chargeLen` edges. `inDischarge` (1 = discharge interval, 0 = charge interval) then stays high for `dischargeLen` cycles, so the cycle length is `chargeLen`+`dischargeLen` clocks.
- R3: A trip during the charge interval does not shorten it. `inDischarge` still rises exactly `chargeLen` edges after the cycle start, and `sinkOn` stays 0 until the next cycle.
- R4: At the edge where a discharge interval ends, a new charge interval begins and `sinkOn` is set again, provided `overNominal` is low.
- R5: If `overNominal` is high at an edge while `sinkOn` is 1 and the bridge is enabled, `sinkOn` goes to 0 at that edge and `tripPulse` is 1 for exactly one cycle.
- R6: A set request (a cycle start in timer mode) is ignored when `overNominal` is high in the same cycle, because reset dominates. A low level of `overNominal` later in that cycle does not set `sinkOn`.
- R7: In sync mode, the counters are idle and `inDischarge` stays 0. A falling edge on `syncIn`, applied between clock edges, sets `sinkOn` at the third rising edge after the change. This allows two synchroniser flops and one edge-detect flop. A rising edge has no effect.
- R8: In sync mode, a falling edge on `syncIn` is ignored while `overNominal` is high or `bridgeEn` is low.
- R9: A length input of 0 acts as 1. With a charge length of 0 or 1 and a discharge length of 1, `inDischarge` toggles every clock and the cycle is two clocks long.
- R10: Sync edges spaced 500 clocks apart and 2500 clocks apart are each accepted. These spacings are the ends of the expected sync-rate range at the nominal clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| bridgeEn | input | 1 | Bridge enable; low holds sink off and timers at start |
| syncMode | input | 1 | 0 = internal timer cycles, 1 = external sync edges |
| overNominal | input | 1 | Synchronised comparator flag, 1 = actual current above nominal |
| syncIn | input | 1 | External sync; falling edge requests an on-phase |
| chargeLen | input | CNT_W | Charge interval length in clocks (0 treated as 1) |
| dischargeLen | input | CNT_W | Discharge interval length in clocks (0 treated as 1) |
| sinkOn | output | 1 | Sink-switch enable (state bit) |
| tripPulse | output | 1 | One-clock pulse when a trip clears the state bit |
| inDischarge | output | 1 | 1 while the discharge interval runs |

## Verification
Two functions can land in the same cycle: the set request for a new cycle and the comparator reset. The bench provokes this by keeping `overNominal` high across the edge where a discharge interval ends. It then expects `sinkOn` to stay low at that edge and also after the flag falls in the middle of the cycle, until the next cycle start sets it. The same collision in sync mode is provoked by dropping `syncIn` while `overNominal` is high. That case is judged by the `sinkOn` value three edges after the change. The timing of `tripPulse` confirms that no set/clear pair happened in between.

// File: rtl/chop_pkg.sv
package chop_pkg;

  typedef enum logic {
    PH_CHARGE    = 1'b0,
    PH_DISCHARGE = 1'b1
  } phase_e;

  // strobes from control to datapath
  typedef struct packed {
    logic holdTimers;
    logic startCharge;
    logic startDischarge;
  } dp_ctrl_t;

  // status from datapath to control
  typedef struct packed {
    logic chargeDone;
    logic dischargeDone;
    logic syncFall;
  } dp_stat_t;

endpackage

// File: rtl/chop_datapath.sv
module chop_datapath
  import chop_pkg::*;
#(
  parameter int CNT_W       = 12,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  dp_ctrl_t         ctrl,
  input  logic             syncIn,
  input  logic [CNT_W-1:0] chargeLen,
  input  logic [CNT_W-1:0] dischargeLen,
  output dp_stat_t         stat
);

  localparam int PIPE_W = SYNC_STAGES + 1;

  logic [CNT_W-1:0]  intervalCnt;
  logic [CNT_W-1:0]  chargeLast;
  logic [CNT_W-1:0]  dischargeLast;
  logic [PIPE_W-1:0] syncPipe;

  // a zero length behaves as one clock
  assign chargeLast    = (chargeLen    == '0) ? '0 : chargeLen    - CNT_W'(1);
  assign dischargeLast = (dischargeLen == '0) ? '0 : dischargeLen - CNT_W'(1);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      intervalCnt <= '0;
    end else if (ctrl.holdTimers || ctrl.startCharge || ctrl.startDischarge) begin
      intervalCnt <= '0;
    end else begin
      intervalCnt <= intervalCnt + CNT_W'(1);
    end
  end

  // synchroniser stages followed by one history flop for edge detection
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncPipe <= '0;
    end else begin
      syncPipe <= {syncPipe[PIPE_W-2:0], syncIn};
    end
  end

  assign stat.chargeDone    = (intervalCnt == chargeLast);
  assign stat.dischargeDone = (intervalCnt == dischargeLast);
  assign stat.syncFall      = syncPipe[PIPE_W-1] & ~syncPipe[PIPE_W-2];

endmodule

// File: rtl/chop_control.sv
module chop_control
  import chop_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     bridgeEn,
  input  logic     syncMode,
  input  logic     overNominal,
  input  dp_stat_t stat,
  output dp_ctrl_t ctrl,
  output logic     sinkOn,
  output logic     tripPulse,
  output logic     inDischarge
);

  phase_e phase;
  logic   wasHeld;
  logic   sinkState;
  logic   tripReg;
  logic   timerHold;
  logic   cycleStart;
  logic   setReq;

  assign timerHold           = !bridgeEn || syncMode;
  assign ctrl.holdTimers     = timerHold;
  assign ctrl.startDischarge = !timerHold && (phase == PH_CHARGE) && stat.chargeDone;
  assign ctrl.startCharge    = !timerHold && (phase == PH_DISCHARGE) && stat.dischargeDone;

  // a cycle starts on leaving hold or when a discharge interval completes
  assign cycleStart = !timerHold && (wasHeld || ctrl.startCharge);
  assign setReq     = syncMode ? stat.syncFall : cycleStart;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phase   <= PH_CHARGE;
      wasHeld <= 1'b1;
    end else begin
      wasHeld <= timerHold;
      if (timerHold)                phase <= PH_CHARGE;
      else if (ctrl.startDischarge) phase <= PH_DISCHARGE;
      else if (ctrl.startCharge)    phase <= PH_CHARGE;
    end
  end

  // set/reset state bit, reset dominant
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sinkState <= 1'b0;
      tripReg   <= 1'b0;
    end else begin
      tripReg <= bridgeEn && sinkState && overNominal;
      if (!bridgeEn)        sinkState <= 1'b0;
      else if (overNominal) sinkState <= 1'b0;
      else if (setReq)      sinkState <= 1'b1;
    end
  end

  assign sinkOn      = sinkState;
  assign tripPulse   = tripReg;
  assign inDischarge = (phase == PH_DISCHARGE);

endmodule

// File: rtl/chop_current_ctrl.sv
module chop_current_ctrl
  import chop_pkg::*;
#(
  parameter int CNT_W       = 12,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             bridgeEn,
  input  logic             syncMode,
  input  logic             overNominal,
  input  logic             syncIn,
  input  logic [CNT_W-1:0] chargeLen,
  input  logic [CNT_W-1:0] dischargeLen,
  output logic             sinkOn,
  output logic             tripPulse,
  output logic             inDischarge
);

  dp_ctrl_t dpCtrl;
  dp_stat_t dpStat;

  chop_datapath #(
    .CNT_W      (CNT_W),
    .SYNC_STAGES(SYNC_STAGES)
  ) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .ctrl        (dpCtrl),
    .syncIn      (syncIn),
    .chargeLen   (chargeLen),
    .dischargeLen(dischargeLen),
    .stat        (dpStat)
  );

  chop_control u_ctl (
    .clk        (clk),
    .rstN       (rstN),
    .bridgeEn   (bridgeEn),
    .syncMode   (syncMode),
    .overNominal(overNominal),
    .stat       (dpStat),
    .ctrl       (dpCtrl),
    .sinkOn     (sinkOn),
    .tripPulse  (tripPulse),
    .inDischarge(inDischarge)
  );

endmodule

// File: rtl/chop_checks.sv
module chop_checks (
  input logic clk,
  input logic rstN,
  input logic bridgeEn,
  input logic syncMode,
  input logic overNominal,
  input logic sinkOn,
  input logic tripPulse,
  input logic inDischarge
);

  p_hold_low_r1: assert property (@(posedge clk) disable iff (!rstN)
    !bridgeEn |=> (!sinkOn && !inDischarge));

  p_trip_clears_r5: assert property (@(posedge clk) disable iff (!rstN)
    (bridgeEn && sinkOn && overNominal) |=> (!sinkOn && tripPulse));

  p_trip_single_r5: assert property (@(posedge clk) disable iff (!rstN)
    tripPulse |=> !tripPulse);

  p_over_blocks_set_r6: assert property (@(posedge clk) disable iff (!rstN)
    (!sinkOn && overNominal) |=> !sinkOn);

  p_sync_no_discharge_r7: assert property (@(posedge clk) disable iff (!rstN)
    (syncMode && bridgeEn) |=> !inDischarge);

  p_rise_needs_enable_r8: assert property (@(posedge clk) disable iff (!rstN)
    $rose(sinkOn) |-> ($past(bridgeEn) && !$past(overNominal)));

endmodule

bind chop_current_ctrl chop_checks u_chk (.*);

// File: tb/sim_chop_current_ctrl.sv
module sim_chop_current_ctrl;

  localparam int CNT_W = 12;
  localparam int L = 4;
  localparam int D = 6;
  localparam int SIG_SINK = 0;
  localparam int SIG_TRIP = 1;
  localparam int SIG_DISC = 2;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic bridgeEn = 1'b0;
  logic syncMode = 1'b0;
  logic overNominal = 1'b0;
  logic syncIn = 1'b1;
  logic [CNT_W-1:0] chargeLen = CNT_W'(L);
  logic [CNT_W-1:0] dischargeLen = CNT_W'(D);
  logic sinkOn, tripPulse, inDischarge;

  int cyc = 0;
  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  typedef struct {
    int    at;
    int    sig;
    bit    val;
    string tag;
  } exp_t;

  exp_t q[$];

  chop_current_ctrl #(.CNT_W(CNT_W)) u0 (
    .clk(clk), .rstN(rstN), .bridgeEn(bridgeEn), .syncMode(syncMode),
    .overNominal(overNominal), .syncIn(syncIn), .chargeLen(chargeLen),
    .dischargeLen(dischargeLen), .sinkOn(sinkOn), .tripPulse(tripPulse),
    .inDischarge(inDischarge)
  );

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  function automatic bit pick(int sig);
    if (sig == SIG_SINK) return sinkOn;
    if (sig == SIG_TRIP) return tripPulse;
    return inDischarge;
  endfunction

  // monitor: compares queued expectations at their cycle
  always @(negedge clk) begin
    while (q.size() > 0 && q[0].at <= cyc) begin
      exp_t it;
      bit   got;
      it  = q.pop_front();
      got = pick(it.sig);
      checks++;
      if (it.at != cyc || got !== it.val) begin
        fails++;
        $display("FAIL %s sig%0d cycle %0d: actual %0b expected %0b (due cycle %0d)",
                 it.tag, it.sig, cyc, got, it.val, it.at);
      end
    end
  end

  task automatic expectAt(int at, int sig, bit val, string tag);
    q.push_back('{at, sig, val, tag});
  endtask

  task automatic waitUntil(int n);
    while (cyc < n) @(negedge clk);
  endtask

  task automatic waitIdle();
    while (q.size() != 0) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic checkNow(bit got, bit want, string tag);
    checks++;
    if (got !== want) begin
      fails++;
      $display("FAIL %s: actual %0b expected %0b", tag, got, want);
    end
  endtask

  initial begin
    int c0;
    repeat (3) @(negedge clk);
    checkNow(sinkOn, 1'b0, "R1 reset sinkOn");
    checkNow(tripPulse, 1'b0, "R1 reset tripPulse");
    checkNow(inDischarge, 1'b0, "R1 reset inDischarge");
    rstN = 1'b1;
    repeat (2) @(negedge clk);

    // timer cycle without trips (R2, R4)
    c0 = cyc;
    bridgeEn = 1'b1;
    expectAt(c0 + 1, SIG_SINK, 1'b1, "R2");
    expectAt(c0 + 1, SIG_DISC, 1'b0, "R2");
    expectAt(c0 + L - 1, SIG_DISC, 1'b0, "R2");
    expectAt(c0 + L, SIG_DISC, 1'b1, "R2");
    expectAt(c0 + L + D - 1, SIG_DISC, 1'b1, "R2");
    expectAt(c0 + L + D, SIG_DISC, 1'b0, "R4");
    expectAt(c0 + L + D, SIG_SINK, 1'b1, "R4");
    waitUntil(c0 + L + D + L + 1);
    bridgeEn = 1'b0; // disable in the middle of discharge
    expectAt(cyc + 1, SIG_SINK, 1'b0, "R1");
    expectAt(cyc + 1, SIG_DISC, 1'b0, "R1");
    waitIdle();

    // early trip: charge still runs full length (R3, R5, R1 restart)
    c0 = cyc;
    bridgeEn = 1'b1;
    waitUntil(c0 + 1);
    overNominal = 1'b1;
    expectAt(c0 + 2, SIG_SINK, 1'b0, "R5");
    expectAt(c0 + 2, SIG_TRIP, 1'b1, "R5");
    waitUntil(c0 + 2);
    overNominal = 1'b0;
    expectAt(c0 + 3, SIG_TRIP, 1'b0, "R5");
    expectAt(c0 + 3, SIG_DISC, 1'b0, "R3");
    expectAt(c0 + L - 1, SIG_DISC, 1'b0, "R3");
    expectAt(c0 + L, SIG_DISC, 1'b1, "R3");
    expectAt(c0 + L + D - 1, SIG_SINK, 1'b0, "R3");
    expectAt(c0 + L + D, SIG_SINK, 1'b1, "R4");
    expectAt(c0 + L + D, SIG_DISC, 1'b0, "R1");
    waitUntil(c0 + L + D);

    // set and reset collide at cycle start (R6)
    c0 = cyc;
    overNominal = 1'b1;
    expectAt(c0 + 1, SIG_TRIP, 1'b1, "R5");
    expectAt(c0 + 2, SIG_TRIP, 1'b0, "R5");
    expectAt(c0 + L + D, SIG_SINK, 1'b0, "R6");
    expectAt(c0 + L + D, SIG_TRIP, 1'b0, "R6");
    waitUntil(c0 + L + D);
    overNominal = 1'b0;
    expectAt(c0 + L + D + 1, SIG_SINK, 1'b0, "R6");
    expectAt(c0 + 2 * (L + D) - 1, SIG_SINK, 1'b0, "R6");
    expectAt(c0 + 2 * (L + D), SIG_SINK, 1'b1, "R4");
    waitIdle();
    bridgeEn = 1'b0;
    waitIdle();

    // minimum lengths, zero acts as one (R9)
    chargeLen = '0;
    dischargeLen = CNT_W'(1);
    @(negedge clk);
    c0 = cyc;
    bridgeEn = 1'b1;
    expectAt(c0 + 1, SIG_SINK, 1'b1, "R9");
    expectAt(c0 + 1, SIG_DISC, 1'b1, "R9");
    expectAt(c0 + 2, SIG_DISC, 1'b0, "R9");
    expectAt(c0 + 3, SIG_DISC, 1'b1, "R9");
    expectAt(c0 + 4, SIG_DISC, 1'b0, "R9");
    waitIdle();
    bridgeEn = 1'b0;
    chargeLen = CNT_W'(L);
    dischargeLen = CNT_W'(D);
    waitIdle();

    // sync mode (R7, R8, R10)
    syncMode = 1'b1;
    bridgeEn = 1'b1;
    c0 = cyc + 5;
    expectAt(c0, SIG_SINK, 1'b0, "R7");
    expectAt(c0, SIG_DISC, 1'b0, "R7");
    waitUntil(c0);
    syncIn = 1'b0;
    expectAt(c0 + 2, SIG_SINK, 1'b0, "R7");
    expectAt(c0 + 3, SIG_SINK, 1'b1, "R7");
    expectAt(c0 + 50, SIG_DISC, 1'b0, "R7");
    waitUntil(c0 + 100);
    overNominal = 1'b1;
    expectAt(c0 + 101, SIG_SINK, 1'b0, "R5");
    expectAt(c0 + 101, SIG_TRIP, 1'b1, "R5");
    waitUntil(c0 + 250);
    syncIn = 1'b1;
    expectAt(c0 + 260, SIG_SINK, 1'b0, "R7");
    waitUntil(c0 + 500);
    syncIn = 1'b0;
    expectAt(c0 + 503, SIG_SINK, 1'b0, "R8");
    waitUntil(c0 + 600);
    overNominal = 1'b0;
    waitUntil(c0 + 750);
    syncIn = 1'b1;
    waitUntil(c0 + 1000);
    syncIn = 1'b0;
    expectAt(c0 + 1003, SIG_SINK, 1'b1, "R10");
    waitUntil(c0 + 1100);
    overNominal = 1'b1;
    waitUntil(c0 + 1102);
    overNominal = 1'b0;
    expectAt(c0 + 1103, SIG_SINK, 1'b0, "R5");
    waitUntil(c0 + 2250);
    syncIn = 1'b1;
    waitUntil(c0 + 3500);
    syncIn = 1'b0;
    expectAt(c0 + 3502, SIG_SINK, 1'b0, "R10");
    expectAt(c0 + 3503, SIG_SINK, 1'b1, "R10");
    waitUntil(c0 + 3600);
    bridgeEn = 1'b0;
    expectAt(c0 + 3601, SIG_SINK, 1'b0, "R1");
    waitUntil(c0 + 3700);
    syncIn = 1'b1;
    waitUntil(c0 + 4000);
    syncIn = 1'b0;
    expectAt(c0 + 4003, SIG_SINK, 1'b0, "R8");
    waitIdle();

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

endmodule